// File: doc/BRIEF.md
# Programmable Slot-Ordered Interrupt Prioritizer

This block picks one winner among nine raw interrupt request lines. The lines fall into two groups. The first group has three fast controllers and two multichannel controllers. The second group has four serial controllers. Each group owns eight ordered priority slots, and each slot holds a 3-bit selector naming the source that competes in it. Slot 1 ranks highest. Several selector codes leave a slot empty. Software sets the two selector words through a small write/read port and may rewrite them at any time.

Each clock, both groups are scanned in parallel. A slot matches when it is active and the source it names is requesting. The fast/multichannel group always ranks above the serial group. A small state machine registers which group won, together with the winning source ID. It has three states: `WIN_NONE`, `WIN_FAST` and `WIN_SERIAL`. From any state, the next state is `WIN_FAST` when a fast/multichannel slot matches. It is `WIN_SERIAL` when only a serial slot matches, and `WIN_NONE` when nothing matches. The outputs are decoded from the registered state.

Top module: `slot_prio_top`

## Requirements
- R1: Request bit n and output ID n denote the same source: IDs 0, 1 and 2 are fast controllers 1 to 3, IDs 3 and 4 are multichannel controllers 1 and 2, and IDs 5 to 8 are serial controllers 1 to 4. A valid winner always had its request asserted.
- R2: `cfg_wsel`=0 addresses the fast/multichannel word and 1 addresses the serial word. Slot k (1..8) occupies bits [3k-1:3k-3]. `cfg_rdata` returns the word chosen by `cfg_rsel`, and bits 31:24 always read zero.
- R3: The fast/multichannel codes map as follows: 000, 001 and 010 select IDs 0, 1 and 2; 100 selects ID 3; 101 selects ID 4. Codes 011, 110 and 111 make the slot inactive.
- R4: Serial codes 000 to 011 select IDs 5 to 8. Any code 1xx makes the slot inactive.
- R5: Within a group, the lowest-numbered active slot whose source is requesting wins. A source mapped to several slots competes at its best slot, so the result stays deterministic.
- R6: A fast/multichannel winner always beats a serial winner.
- R7: The outputs are registered. They reflect the requests and configuration present at the previous rising edge. A configuration write applies from the edge after the write edge.
- R8: `win_valid` is low, and `win_id` is 0, when no active slot has a pending request.
- R9: Reset loads both words with codes 000 to 111 in slots 1 to 8, which reads back as 0x00FAC688. Reset also clears `win_valid` and `win_id`.
- R10: Rewriting a selector word while requests are pending changes the winner without any reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 9 | Raw request lines, bit n = source ID n |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wsel | input | 1 | Write target: 0 fast/multichannel, 1 serial |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rsel | input | 1 | Read target: 0 fast/multichannel, 1 serial |
| cfg_rdata | output | 32 | Selected configuration word |
| win_valid | output | 1 | A winner is reported |
| win_id | output | 4 | Winning source ID |

## Verification
The assertions check four things on every cycle. A reported winner had its request line set on the previous edge. No requests at all means no winner. A fast/multichannel match on one edge produces a fast/multichannel ID on the next. A serial ID never appears while a fast/multichannel slot was matching. Only the directed scenarios can show that each selector code lands on the right source and that inactive codes are skipped. They also cover the choice between duplicate and competing slots, the reset map and its readback, reserved-bit masking, and the exact cycle at which a rewritten word takes effect.

// File: rtl/slot_prio_pkg.sv
`timescale 1ns/1ps
package slot_prio_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_FAST   = 2'd1,
        WIN_SERIAL = 2'd2
    } win_state_e;

    typedef struct packed {
        logic       act;
        logic [2:0] idx;
    } slot_dec_t;

    function automatic slot_dec_t decode_fast(input logic [SEL_W-1:0] code);
        slot_dec_t d;
        d.act = 1'b1;
        d.idx = 3'd0;
        case (code)
            3'b000, 3'b001, 3'b010: d.idx = code;
            3'b100:                 d.idx = 3'd3;
            3'b101:                 d.idx = 3'd4;
            default:                d.act = 1'b0;
        endcase
        return d;
    endfunction

    function automatic slot_dec_t decode_serial(input logic [SEL_W-1:0] code);
        slot_dec_t d;
        d.act = ~code[2];
        d.idx = {1'b0, code[1:0]};
        return d;
    endfunction
endpackage

// File: rtl/slot_prio_cfg.sv
`timescale 1ns/1ps
module slot_prio_cfg
    import slot_prio_pkg::*;
#(
    parameter int NUM_POS = 8,
    parameter int WORD_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic                       wsel,
    input  logic [WORD_W-1:0]          wdata,
    input  logic                       rsel,
    output logic [WORD_W-1:0]          rdata,
    output logic [NUM_POS*SEL_W-1:0]   fast_slots,
    output logic [NUM_POS*SEL_W-1:0]   serial_slots
);
    localparam int SLOTS_W = NUM_POS * SEL_W;

    logic [SLOTS_W-1:0] fast_q;
    logic [SLOTS_W-1:0] serial_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_POS; p++) begin
                fast_q[p*SEL_W +: SEL_W]   <= SEL_W'(p);
                serial_q[p*SEL_W +: SEL_W] <= SEL_W'(p);
            end
        end else if (we) begin
            if (wsel) serial_q <= wdata[SLOTS_W-1:0];
            else      fast_q   <= wdata[SLOTS_W-1:0];
        end
    end

    always_comb begin
        rdata = WORD_W'(rsel ? serial_q : fast_q);
    end

    assign fast_slots   = fast_q;
    assign serial_slots = serial_q;
endmodule

// File: rtl/slot_prio_scan.sv
`timescale 1ns/1ps
module slot_prio_scan
    import slot_prio_pkg::*;
#(
    parameter int NUM_POS   = 8,
    parameter int NUM_SRC   = 5,
    parameter bit SERIAL_CD = 1'b0
) (
    input  logic [NUM_POS*SEL_W-1:0] slots,
    input  logic [NUM_SRC-1:0]       req,
    output logic                     hit,
    output logic [2:0]               idx
);
    logic [7:0]  req_x;
    slot_dec_t   dec   [NUM_POS];
    logic [NUM_POS-1:0] match;

    assign req_x = 8'(req);

    for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
        if (SERIAL_CD) begin : g_ser
            assign dec[p] = decode_serial(slots[p*SEL_W +: SEL_W]);
        end else begin : g_fst
            assign dec[p] = decode_fast(slots[p*SEL_W +: SEL_W]);
        end
        assign match[p] = dec[p].act & req_x[dec[p].idx];
    end

    always_comb begin
        hit = 1'b0;
        idx = 3'd0;
        for (int p = NUM_POS - 1; p >= 0; p--) begin
            if (match[p]) begin
                hit = 1'b1;
                idx = dec[p].idx;
            end
        end
    end
endmodule

// File: rtl/slot_prio_top.sv
`timescale 1ns/1ps
module slot_prio_top
    import slot_prio_pkg::*;
#(
    parameter int NUM_POS = 8,
    parameter int WORD_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [8:0]        req,
    input  logic              cfg_we,
    input  logic              cfg_wsel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              cfg_rsel,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              win_valid,
    output logic [3:0]        win_id
);
    localparam int FAST_SRC   = 5;
    localparam int SERIAL_SRC = 4;
    localparam int ID_W       = 4;
    localparam int SLOTS_W    = NUM_POS * SEL_W;

    logic [SLOTS_W-1:0] fast_slots, serial_slots;
    logic               fast_hit, serial_hit;
    logic [2:0]         fast_idx, serial_idx;
    win_state_e         state_q, state_d;
    logic [ID_W-1:0]    src_q, src_d;

    slot_prio_cfg #(.NUM_POS(NUM_POS), .WORD_W(WORD_W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wsel(cfg_wsel), .wdata(cfg_wdata),
        .rsel(cfg_rsel), .rdata(cfg_rdata),
        .fast_slots(fast_slots), .serial_slots(serial_slots)
    );

    slot_prio_scan #(.NUM_POS(NUM_POS), .NUM_SRC(FAST_SRC), .SERIAL_CD(1'b0)) u_scan_fast (
        .slots(fast_slots), .req(req[FAST_SRC-1:0]), .hit(fast_hit), .idx(fast_idx)
    );

    slot_prio_scan #(.NUM_POS(NUM_POS), .NUM_SRC(SERIAL_SRC), .SERIAL_CD(1'b1)) u_scan_serial (
        .slots(serial_slots), .req(req[FAST_SRC+SERIAL_SRC-1:FAST_SRC]),
        .hit(serial_hit), .idx(serial_idx)
    );

    // next-state: fast group ranks above serial group
    always_comb begin
        state_d = WIN_NONE;
        src_d   = '0;
        unique case ({fast_hit, serial_hit})
            2'b00: begin
                state_d = WIN_NONE;
                src_d   = '0;
            end
            2'b01: begin
                state_d = WIN_SERIAL;
                src_d   = ID_W'(serial_idx) + ID_W'(FAST_SRC);
            end
            2'b10, 2'b11: begin
                state_d = WIN_FAST;
                src_d   = ID_W'(fast_idx);
            end
            default: begin
                state_d = WIN_NONE;
                src_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_NONE;
            src_q   <= '0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        unique case (state_q)
            WIN_NONE: begin
                win_valid = 1'b0;
                win_id    = '0;
            end
            WIN_FAST, WIN_SERIAL: begin
                win_valid = 1'b1;
                win_id    = src_q;
            end
            default: begin
                win_valid = 1'b0;
                win_id    = '0;
            end
        endcase
    end
endmodule

// File: rtl/slot_prio_chk.sv
`timescale 1ns/1ps
module slot_prio_chk (
    input logic       clk,
    input logic       rst,
    input logic [8:0] req,
    input logic       win_valid,
    input logic [3:0] win_id,
    input logic       fast_hit
);
    // R1
    winner_had_req_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> ((($past(req) >> win_id) & 9'd1) != 9'd0));

    // R1
    id_range_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (win_id <= 4'd8));

    // R8
    quiet_no_win_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(req) == 9'd0) |-> !win_valid);

    // R6
    fast_ranks_first_chk: assert property (@(posedge clk) disable iff (rst)
        (win_valid && win_id >= 4'd5) |-> !$past(fast_hit));

    // R7
    fast_next_edge_chk: assert property (@(posedge clk) disable iff (rst)
        fast_hit |=> (win_valid && win_id <= 4'd4));
endmodule

bind slot_prio_top slot_prio_chk u_chk (
    .clk(clk), .rst(rst), .req(req),
    .win_valid(win_valid), .win_id(win_id), .fast_hit(fast_hit)
);

// File: tb/slot_prio_top_test.sv
`timescale 1ns/1ps
module slot_prio_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  req;
    logic        cfg_we, cfg_wsel, cfg_rsel;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        win_valid;
    logic [3:0]  win_id;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    slot_prio_top uut (
        .clk(clk), .rst(rst), .req(req), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
        .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .win_valid(win_valid), .win_id(win_id)
    );

    function automatic logic [31:0] pack8(input logic [2:0] c1, c2, c3, c4,
                                          input logic [2:0] c5, c6, c7, c8);
        return {8'h00, c8, c7, c6, c5, c4, c3, c2, c1};
    endfunction

    task automatic expect_win(input logic ev, input logic [3:0] eid, input string tag);
        checks++;
        if (win_valid !== ev || win_id !== eid) begin
            failures++;
            $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
                     tag, win_valid, win_id, ev, eid);
        end
    endtask

    task automatic expect_word(input logic sel, input logic [31:0] exp, input string tag);
        cfg_rsel = sel;
        #0.5;
        checks++;
        if (cfg_rdata !== exp) begin
            failures++;
            $display("FAIL %s: got rdata=%h, expected %h", tag, cfg_rdata, exp);
        end
    endtask

    task automatic apply_req(input logic [8:0] v);
        @(negedge clk);
        req = v;
        @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wsel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        expect_win(1'b0, 4'd0, "R9 reset outputs");
        expect_word(1'b0, 32'h00FA_C688, "R9 fast reset map");
        expect_word(1'b1, 32'h00FA_C688, "R9 serial reset map");
    endtask

    task automatic t_default_map;
        apply_req(9'h080); expect_win(1'b1, 4'd7, "R4 serial3 default");
        apply_req(9'h024); expect_win(1'b1, 4'd2, "R6 fast3 beats serial1");
        apply_req(9'h008); expect_win(1'b1, 4'd3, "R1 multichannel1");
        apply_req(9'h010); expect_win(1'b1, 4'd4, "R1 multichannel2");
        apply_req(9'h1FF); expect_win(1'b1, 4'd0, "R5 all pending");
        apply_req(9'h000); expect_win(1'b0, 4'd0, "R8 nothing pending");
    endtask

    task automatic t_latency;
        @(negedge clk);
        req = 9'h002;
        #1;
        expect_win(1'b0, 4'd0, "R7 before edge");
        @(posedge clk);
        #1;
        expect_win(1'b1, 4'd1, "R7 after edge");
    endtask

    task automatic t_remap_fast;
        write_cfg(1'b0, pack8(3'b101, 3'b000, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011));
        expect_word(1'b0, pack8(3'b101, 3'b000, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011),
                    "R2 fast readback");
        apply_req(9'h011); expect_win(1'b1, 4'd4, "R5 multichannel2 in slot1");
        apply_req(9'h044); expect_win(1'b1, 4'd6, "R3 unmapped fast3 loses to serial2");
        apply_req(9'h004); expect_win(1'b0, 4'd0, "R8 only unmapped source");
    endtask

    task automatic t_fast_inactive_codes;
        write_cfg(1'b0, pack8(3'b110, 3'b111, 3'b011, 3'b010, 3'b011, 3'b011, 3'b011, 3'b011));
        apply_req(9'h007); expect_win(1'b1, 4'd2, "R3 codes 110/111/011 skipped");
    endtask

    task automatic t_duplicate;
        write_cfg(1'b0, pack8(3'b001, 3'b000, 3'b001, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011));
        apply_req(9'h003); expect_win(1'b1, 4'd1, "R5 duplicate best slot");
        apply_req(9'h001); expect_win(1'b1, 4'd0, "R5 next slot");
    endtask

    task automatic t_serial_codes;
        write_cfg(1'b0, pack8(3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011));
        write_cfg(1'b1, pack8(3'b100, 3'b111, 3'b010, 3'b000, 3'b101, 3'b101, 3'b101, 3'b101));
        apply_req(9'h0A1); expect_win(1'b1, 4'd7, "R4 serial3 above serial1");
        apply_req(9'h040); expect_win(1'b0, 4'd0, "R4 serial2 unmapped");
    endtask

    task automatic t_reserved;
        write_cfg(1'b1, 32'hFFFF_FFFF);
        expect_word(1'b1, 32'h00FF_FFFF, "R2 reserved bits zero");
        apply_req(9'h1E0); expect_win(1'b0, 4'd0, "R4 all 1xx inactive");
    endtask

    task automatic t_dynamic;
        write_cfg(1'b1, pack8(3'b000, 3'b001, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111));
        apply_req(9'h060); expect_win(1'b1, 4'd5, "R10 serial1 first");
        write_cfg(1'b1, pack8(3'b001, 3'b000, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111));
        #1;
        expect_win(1'b1, 4'd5, "R7 write not yet applied");
        @(posedge clk);
        #1;
        expect_win(1'b1, 4'd6, "R10 remap takes effect");
    endtask

    initial begin
        rst = 1'b1; req = '0; cfg_we = 1'b0; cfg_wsel = 1'b0; cfg_wdata = '0; cfg_rsel = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_default_map();
        apply_req(9'h000);
        t_latency();
        t_remap_fast();
        t_fast_inactive_codes();
        t_duplicate();
        t_serial_codes();
        t_reserved();
        t_dynamic();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end
endmodule